// File: doc/BRIEF.md
# Keyed Lane-Swapping Parity Port

This block sits between a host request stream and a memory that is one bit wider than the data it stores, for example eight data lines plus a ninth line. When reset is released, it captures a small random key from a seed input. The key chooses which physical data line carries the parity bit. It also chooses whether that parity is even or odd. On a write, the data bit that the chosen line would normally carry moves onto the extra top line. A memory that only stores data and invents a parity bit on the fly has no means of knowing where the parity sits or which polarity is in use.

Reads come back from the memory as a plain valid-qualified return. The block undoes the lane swap, recomputes parity over the recovered data and raises a fault flag in the same cycle when the stored parity disagrees. Both paths are combinational. The only state in the block is the key register and its captured flag.

Back-pressure works as follows. A request moves when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` simply mirrors `mem_ready` once the key is held, and it is low before that. The memory side sees `mem_valid` only when a key is held. Read returns cannot be stalled: the host must accept `rd_valid` whenever it is raised.

Top module: `lane_key_parity_if`

## Requirements
- R1: On the first rising edge after `rst_n` goes high, the key is loaded from `key_seed`. Changes to `key_seed` after that have no effect on the lane mapping until the next reset.
- R2: `req_ready` and `mem_valid` stay low while reset is asserted and during the cycle before the key is captured.
- R3: On a write, memory line number `key[3:1]` carries the parity bit. The top line `mem_wdata[8]` carries logical bit `req_wdata[key[3:1]]`. Every other line i carries `req_wdata[i]`.
- R4: The parity polarity follows `key[0]`. With `key[0]`=0, the nine written lines hold an even number of ones. With `key[0]`=1, they hold an odd number.
- R5: Once the key is held, `mem_valid` equals `req_valid` and `req_ready` equals `mem_ready`. `mem_write`, `mem_addr` and the mapped data pass through in the same cycle.
- R6: In the cycle `mem_rvalid` is high, `rd_valid` is high. `rd_data[key[3:1]]` is taken from `mem_rdata[8]`, and every other `rd_data[i]` is taken from `mem_rdata[i]`.
- R7: `rd_fault` is high only together with `rd_valid`. It is high when the recovered data, combined with the line `key[3:1]`, fails the polarity rule of R4. A single flipped bit on any of the nine lines therefore raises it.
- R8: Consider a memory that ignores the extra line and returns plain even parity of lines 0..7 on line 8. Every read from it faults when `key[0]`=1. With `key[0]`=0 it returns intact data without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_seed | input | 4 | Random seed sampled once after reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Request address |
| req_wdata | input | 8 | Logical write data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory can take a request |
| mem_write | output | 1 | Memory write enable |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 9 | Physical write lines, parity swapped in |
| mem_rvalid | input | 1 | Memory read return valid |
| mem_rdata | input | 9 | Physical read lines |
| rd_valid | output | 1 | Read data valid to host |
| rd_data | output | 8 | Logical read data with the swap undone |
| rd_fault | output | 1 | Parity mismatch on this read |

## Verification
The hardest situation to reach from the ports is a read whose physical lines disagree with what was written. The fake-parity case is the most important example, because a correct memory never produces it. The bench's memory model has two extra modes for this. One XORs a chosen mask into the returned lines. The other keeps only lines 0..7 and regenerates line 8 as plain even parity. All sixteen keys are swept, so every lane and both polarities meet both corruptions. Each key is also checked while `key_seed` is changed after capture, and one key runs with a stalling memory to exercise the ready path.

// File: rtl/lkp_pkg.sv
package lkp_pkg;

  // Parity sense selected by the low key bit.
  typedef enum logic {
    POL_EVEN = 1'b0,
    POL_ODD  = 1'b1
  } pol_e;

  // Default geometry of the port.
  localparam int unsigned LKP_DATA_W = 8;
  localparam int unsigned LKP_ADDR_W = 8;

  // Parity bit for a logical data word under the given polarity.
  function automatic logic lkp_parity(input logic [LKP_DATA_W-1:0] d, input pol_e p);
    return (^d) ^ logic'(p);
  endfunction

endpackage

// File: rtl/lkp_key_latch.sv
module lkp_key_latch #(
  parameter int unsigned KEY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] seed_i,
  output logic [KEY_W-1:0] key_o,
  output logic             key_ok_o
);

  // The key is taken exactly once, on the first edge out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_o    <= '0;
      key_ok_o <= 1'b0;
    end else if (!key_ok_o) begin
      key_o    <= seed_i;
      key_ok_o <= 1'b1;
    end
  end

  // R1: once captured, the key neither changes nor is dropped before reset.
  a_r1_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
    key_ok_o |=> (key_ok_o && $stable(key_o)));

endmodule

// File: rtl/lkp_lane_mapper.sv
module lkp_lane_mapper
  import lkp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANE_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANE_W-1:0] lane_i,
  input  pol_e              pol_i,
  output logic [DATA_W:0]   phys_o
);

  logic par;

  assign par = (^data_i) ^ logic'(pol_i);

  // The displaced logical bit rides on the extra top line.
  assign phys_o[DATA_W] = data_i[lane_i];

  for (genvar i = 0; i < DATA_W; i++) begin : g_line
    assign phys_o[i] = (lane_i == LANE_W'(i)) ? par : data_i[i];
  end

endmodule

// File: rtl/lkp_lane_unmapper.sv
module lkp_lane_unmapper
  import lkp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANE_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rvalid_i,
  input  logic [DATA_W:0]   phys_i,
  input  logic [LANE_W-1:0] lane_i,
  input  pol_e              pol_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fault_o
);

  logic expected_par;
  logic stored_par;

  for (genvar i = 0; i < DATA_W; i++) begin : g_line
    assign data_o[i] = (lane_i == LANE_W'(i)) ? phys_i[DATA_W] : phys_i[i];
  end

  assign stored_par   = phys_i[lane_i];
  assign expected_par = (^data_o) ^ logic'(pol_i);
  assign valid_o      = rvalid_i;
  assign fault_o      = rvalid_i & (expected_par != stored_par);

  // R7: a fault is only ever reported alongside a valid read return.
  a_r7_fault_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> valid_o);

endmodule

// File: rtl/lane_key_parity_if.sv
module lane_key_parity_if
  import lkp_pkg::*;
#(
  parameter int unsigned ADDR_W = LKP_ADDR_W,
  parameter int unsigned DATA_W = LKP_DATA_W,
  // Derived: lane index width; keep at its default.
  parameter int unsigned LANE_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W:0]   key_seed,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W:0]   mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W:0]   mem_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_fault
);

  localparam int unsigned KEY_W = LANE_W + 1;

  logic [KEY_W-1:0]  key;
  logic              key_ok;
  logic [LANE_W-1:0] lane;
  pol_e              pol;

  lkp_key_latch #(.KEY_W(KEY_W)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_i   (key_seed),
    .key_o    (key),
    .key_ok_o (key_ok)
  );

  // Upper key bits pick the lane, the lowest bit picks the polarity.
  assign lane = key[KEY_W-1:1];
  assign pol  = pol_e'(key[0]);

  // Request channel: pass-through gated by the key being held.
  assign mem_valid = req_valid & key_ok;
  assign req_ready = mem_ready & key_ok;
  assign mem_write = req_write;
  assign mem_addr  = req_addr;

  lkp_lane_mapper #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_map (
    .data_i (req_wdata),
    .lane_i (lane),
    .pol_i  (pol),
    .phys_o (mem_wdata)
  );

  lkp_lane_unmapper #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_unmap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rvalid_i (mem_rvalid),
    .phys_i   (mem_rdata),
    .lane_i   (lane),
    .pol_i    (pol),
    .valid_o  (rd_valid),
    .data_o   (rd_data),
    .fault_o  (rd_fault)
  );

  // R2: nothing reaches the memory before the key exists.
  a_r2_quiet_before_key: assert property (@(posedge clk) disable iff (!rst_n)
    !key_ok |-> (!req_ready && !mem_valid));

  // R4: the nine physical lines of a write obey the keyed polarity.
  a_r4_line_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> ((^mem_wdata) == key[0]));

  // R3: the top line carries the logical bit displaced by parity.
  a_r3_top_line: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> (mem_wdata[DATA_W] == req_wdata[lane]));

endmodule

// File: tb/lane_key_parity_if_test.sv
module lane_key_parity_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    key_seed = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, mem_valid, mem_write;
  logic [AW-1:0] mem_addr;
  logic [DW:0]   mem_wdata;
  logic          mem_ready;
  logic          mem_rvalid = 1'b0;
  logic [DW:0]   mem_rdata = '0;
  logic          rd_valid, rd_fault;
  logic [DW-1:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_key_parity_if uut (
    .clk(clk), .rst_n(rst_n), .key_seed(key_seed),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_fault(rd_fault)
  );

  // Memory model: honest 9-bit store, optional fake parity, optional flips.
  logic [DW:0] store [0:15];
  logic        fake_mode = 1'b0;
  logic [DW:0] flip_mask = '0;
  logic        stall = 1'b0;
  logic [1:0]  stall_cnt = '0;

  assign mem_ready = !stall || (stall_cnt == 2'd3);

  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 2'd1;
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_write) store[mem_addr[3:0]] <= mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        if (fake_mode)
          mem_rdata <= {^store[mem_addr[3:0]][DW-1:0], store[mem_addr[3:0]][DW-1:0]};
        else
          mem_rdata <= store[mem_addr[3:0]] ^ flip_mask;
      end
    end
  end

  typedef struct packed { logic [DW-1:0] data; logic fault; } exp_t;
  exp_t exp_q[$];
  int vectors = 0;
  int miscompares = 0;
  logic done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW:0] map_exp(input logic [DW-1:0] d, input logic [3:0] k);
    logic [DW:0] r;
    r = {d[k[3:1]], d};
    r[k[3:1]] = (^d) ^ k[0];
    return r;
  endfunction

  // Monitor: pops the scoreboard as read returns appear.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R6 unexpected read return", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R6 read data", 32'(rd_data), 32'(e.data));
        check("R7/R8 read fault", 32'(rd_fault), 32'(e.fault));
      end
    end
  end

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [3:0] k);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      check("R5 ready follows memory", 32'(req_ready), 32'(mem_ready));
      check("R5 valid passes", 32'(mem_valid), 32'd1);
      @(negedge clk); #1;
    end
    check("R5 addr passes", 32'(mem_addr), 32'(a));
    check("R5 write passes", 32'(mem_write), 32'(wr));
    if (wr) begin
      check("R1/R3 mapped lines", 32'(mem_wdata), 32'(map_exp(d, k)));
      check("R4 polarity", 32'(^mem_wdata), 32'(k[0]));
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic f,
                         input logic [3:0] k);
    exp_t e;
    e.data = d; e.fault = f;
    exp_q.push_back(e);
    issue(1'b0, a, '0, k);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_key(input logic [3:0] k);
    logic [DW-1:0] pat [4];
    logic [DW-1:0] exp_d;
    int j;
    rst_n = 1'b0; key_seed = k; stall = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check("R2 ready low in reset", 32'(req_ready), 32'd0);
    check("R2 no valid in reset", 32'(rd_valid), 32'd0);
    req_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b1; #1;
    check("R2 ready low before capture", 32'(req_ready), 32'd0);
    check("R2 mem_valid low before capture", 32'(mem_valid), 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    key_seed = ~k;   // R1: must be ignored from here on
    #1;
    check("R2 ready after capture", 32'(req_ready), 32'd1);
    stall = (k == 4'd5);
    pat[0] = 8'h00; pat[1] = 8'hFF;
    pat[2] = 8'(k) * 8'd37 ^ 8'hA5; pat[3] = 8'h01 << k[2:0];
    for (int i = 0; i < 4; i++) issue(1'b1, AW'(i), pat[i], k);
    for (int i = 0; i < 4; i++) do_read(AW'(i), pat[i], 1'b0, k);
    stall = 1'b0;
    // R7: single flipped line
    j = int'(k) % 9;
    flip_mask = 9'(1) << j;
    exp_d = pat[2];
    if (j == 8) exp_d[k[3:1]] = ~exp_d[k[3:1]];
    else if (j != int'(k[3:1])) exp_d[j] = ~exp_d[j];
    do_read(AW'(2), exp_d, 1'b1, k);
    flip_mask = '0;
    // R8: fake parity memory
    fake_mode = 1'b1;
    exp_d = pat[2];
    exp_d[k[3:1]] = exp_d[k[3:1]] ^ k[0];
    do_read(AW'(2), exp_d, k[0], k);
    fake_mode = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) run_key(4'(k));
    repeat (3) @(negedge clk);
    check("R6 all returns seen", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog (all) actual=timeout expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule